// File: doc/BRIEF.md
# Wiper Position Register with Bus-Driven Stepping

This block holds the position of a digitally controlled resistor wiper as an 8-bit code and turns that code into a one-hot enable vector for 256 tap switches. Code 00h selects the tap at the low end of the resistor chain and code FFh selects the tap at the high end. The register is volatile: after reset it sits at code 00h until the surrounding controller restores the saved position.

A new position arrives on a single valid/ready load channel. That channel carries three kinds of load: a direct write from the serial host, a copy from one of the first-bank data registers, and the power-up recall of the first data register. A load is taken on any clock edge where `ld_valid` and `ld_ready` are both high. The block drops `ld_ready` for as long as stepping mode is active, and the upstream holds its data until `ld_ready` returns. There is no other back-pressure.

Once the serial front end has acknowledged a step command, it pulses `step_start`. From then on the block watches the raw serial clock and data lines itself. At the falling edge of each complete clock-high pulse it moves the code by one: up if the data line was high, down if it was low. The code holds at its end values. A stop or start condition, meaning a data edge while the clock is high, ends the mode and causes no step. Both bus lines pass through a synchronizer before use.

Top module: `wiper_step_top`

## Requirements
- R1: After reset the code is 00h, the tap vector has only bit 0 set, and `ld_ready` is high.
- R2: When `ld_valid` and `ld_ready` are both high at a clock edge, the code equals `ld_data` after that edge. Host writes, bank-0 transfers and power-up recalls all use this channel in the same way.
- R3: The tap vector has exactly one bit set at all times. One edge after the code changes, that bit is the one whose index equals the code.
- R4: Code 00h enables tap bit 0, which is the low terminal. Code FFh enables tap bit 255, which is the high terminal.
- R5: In stepping mode, a serial clock high pulse during which the data line stays high increments the code by one. The change is applied when the falling edge of that pulse is detected.
- R6: In stepping mode, a serial clock high pulse during which the data line stays low decrements the code by one.
- R7: Stepping saturates. An increment at FFh and a decrement at 00h leave the code unchanged.
- R8: A low-to-high data transition while the clock is high (stop) ends stepping mode without a step. Later clock pulses do not move the code.
- R9: While stepping mode is active, `ld_ready` is low and an offered load leaves the code unchanged.
- R10: A high-to-low data transition while the clock is high (start) also ends stepping mode without a step, and `ld_ready` returns high.
- R11: Outside stepping mode, activity on the serial clock and data lines has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request on the position channel |
| ld_ready | output | 1 | Load channel can accept; low during stepping mode |
| ld_data | input | 8 | Position to load |
| step_start | input | 1 | One-cycle pulse: the step command was acknowledged |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line |
| wiper_code | output | 8 | Current wiper code |
| tap_en | output | 256 | One-hot tap switch enables |

## Verification
A load changes `wiper_code` on the edge that accepts it, and `tap_en` one edge later. A serial clock falling edge driven between edges reaches the code on the third rising edge after it: two edges go through the synchronizer and the third is the edge where the fall is detected. The tap vector follows one edge after that. The bench keeps a behavioural model that follows exactly these delays and compares the code, the tap vector and `ld_ready` with it at every falling clock edge. The scenario checks are sampled only after each bus phase has had five clock cycles to settle.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef struct packed {
    logic scl_now;
    logic scl_prev;
    logic sda_now;
    logic sda_prev;
  } bus_view_t;
endpackage

// File: rtl/wiper_bus_sampler.sv
module wiper_bus_sampler
  import wiper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_in,
  input  logic      sda_in,
  output bus_view_t view
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_chain;
  logic [LAST:0] sda_chain;
  logic          scl_hold;
  logic          sda_hold;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain[0] <= scl_in;
          sda_chain[0] <= sda_in;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[LAST-1:0], scl_in};
          sda_chain <= {sda_chain[LAST-1:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_hold <= 1'b1;
      sda_hold <= 1'b1;
    end else begin
      scl_hold <= scl_chain[LAST];
      sda_hold <= sda_chain[LAST];
    end
  end

  assign view.scl_now  = scl_chain[LAST];
  assign view.scl_prev = scl_hold;
  assign view.sda_now  = sda_chain[LAST];
  assign view.sda_prev = sda_hold;
endmodule

// File: rtl/wiper_step_tracker.sv
module wiper_step_tracker
  import wiper_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_start,
  input  bus_view_t view,
  output logic      mode_on,
  output logic      step_up,
  output logic      step_dn
);
  logic active_q;
  logic armed_q;
  logic dir_q;
  logic clk_rise;
  logic clk_fall;
  logic line_event;

  assign clk_rise   = view.scl_now & ~view.scl_prev;
  assign clk_fall   = ~view.scl_now & view.scl_prev;
  assign line_event = view.scl_now & view.scl_prev & (view.sda_now ^ view.sda_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      dir_q    <= 1'b0;
    end else if (step_start) begin
      active_q <= 1'b1;
      armed_q  <= 1'b0;
    end else if (active_q) begin
      if (line_event) begin
        active_q <= 1'b0;
        armed_q  <= 1'b0;
      end else if (clk_rise) begin
        armed_q <= 1'b1;
        dir_q   <= view.sda_now;
      end else if (clk_fall) begin
        armed_q <= 1'b0;
      end
    end
  end

  logic commit;
  assign commit  = active_q & armed_q & clk_fall & ~step_start;
  assign step_up = commit & dir_q;
  assign step_dn = commit & ~dir_q;
  assign mode_on = active_q;
endmodule

// File: rtl/wiper_code_reg.sv
module wiper_code_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [WIDTH-1:0] code
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  logic [WIDTH-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= BOT;
    end else if (load) begin
      code_q <= load_val;
    end else if (step_up && code_q != TOP) begin
      code_q <= code_q + 1'b1;
    end else if (step_dn && code_q != BOT) begin
      code_q <= code_q - 1'b1;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/wiper_tap_decoder.sv
module wiper_tap_decoder #(
  parameter int WIDTH = 8,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] code,
  output logic [TAPS-1:0]  taps
);
  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      localparam logic RST_BIT = (i == 0);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps[i] <= RST_BIT;
        else        taps[i] <= (code == WIDTH'(i));
      end
    end
  endgenerate
endmodule

// File: rtl/wiper_step_top.sv
module wiper_step_top
  import wiper_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int TAPS       = 1 << WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             step_start,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic [WIDTH-1:0] wiper_code,
  output logic [TAPS-1:0]  tap_en
);
  bus_view_t view;
  logic      step_mode;
  logic      up_pulse;
  logic      dn_pulse;
  logic      take_load;

  wiper_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .view(view)
  );

  wiper_step_tracker u_tracker (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .view(view),
    .mode_on(step_mode), .step_up(up_pulse), .step_dn(dn_pulse)
  );

  assign ld_ready  = ~step_mode;
  assign take_load = ld_valid & ld_ready;

  wiper_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk(clk), .rst_n(rst_n), .load(take_load), .load_val(ld_data),
    .step_up(up_pulse), .step_dn(dn_pulse), .code(wiper_code)
  );

  wiper_tap_decoder #(.WIDTH(WIDTH)) u_dec (
    .clk(clk), .rst_n(rst_n), .code(wiper_code), .taps(tap_en)
  );
endmodule

// File: rtl/wiper_step_chk.sv
module wiper_step_chk #(
  parameter int WIDTH = 8,
  localparam int TAPS = 1 << WIDTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic [WIDTH-1:0] ld_data,
  input logic             step_mode,
  input logic [WIDTH-1:0] wiper_code,
  input logic [TAPS-1:0]  tap_en
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  a_r3_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) == 1);

  a_r3_tap_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tap_en[$past(wiper_code)]);

  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready |=> wiper_code == $past(ld_data));

  a_r7_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_code == TOP && !(ld_valid && ld_ready) |=> wiper_code != '0);

  a_r7_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_code == '0 && !(ld_valid && ld_ready) |=> wiper_code != TOP);

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && ld_ready) |=> (wiper_code == $past(wiper_code)) ||
      (wiper_code == $past(wiper_code) + 1'b1) ||
      (wiper_code == $past(wiper_code) - 1'b1));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_mode && !ld_valid |=> $stable(wiper_code));

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    step_mode && ld_valid |-> !ld_ready);
endmodule

bind wiper_step_top wiper_step_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_data(ld_data), .step_mode(step_mode), .wiper_code(wiper_code),
  .tap_en(tap_en)
);

// File: tb/wiper_step_tb.sv
module wiper_step_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_valid = 1'b0;
  logic         ld_ready;
  logic [7:0]   ld_data = 8'h00;
  logic         step_start = 1'b0;
  logic         scl_in = 1'b1;
  logic         sda_in = 1'b1;
  logic [7:0]   wiper_code;
  logic [255:0] tap_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  wiper_step_top dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .step_start(step_start), .scl_in(scl_in),
    .sda_in(sda_in), .wiper_code(wiper_code), .tap_en(tap_en)
  );

  // behavioural reference: two-flop line delay, then edge detect
  int  m_code, m_tap_code;
  bit  m_c1, m_c2, m_cp, m_d1, m_d2, m_dp;
  bit  m_act, m_armed, m_dir;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code <= 0; m_tap_code <= 0;
      m_c1 <= 1; m_c2 <= 1; m_cp <= 1; m_d1 <= 1; m_d2 <= 1; m_dp <= 1;
      m_act <= 0; m_armed <= 0; m_dir <= 0;
    end else begin
      m_tap_code <= m_code;
      if (ld_valid && !m_act) m_code <= ld_data;
      else if (m_act && !step_start && m_armed && !m_c2 && m_cp) begin
        if (m_dir && m_code < 255) m_code <= m_code + 1;
        if (!m_dir && m_code > 0)  m_code <= m_code - 1;
      end
      if (step_start) begin
        m_act <= 1; m_armed <= 0;
      end else if (m_act) begin
        if (m_c2 && m_cp && (m_d2 != m_dp)) begin
          m_act <= 0; m_armed <= 0;
        end else if (m_c2 && !m_cp) begin
          m_armed <= 1; m_dir <= m_d2;
        end else if (!m_c2 && m_cp) m_armed <= 0;
      end
      m_c1 <= scl_in; m_c2 <= m_c1; m_cp <= m_c2;
      m_d1 <= sda_in; m_d2 <= m_d1; m_dp <= m_d2;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (wiper_code != 8'(m_code) || tap_en != (256'(1) << m_tap_code) ||
          ld_ready != !m_act) begin
        errors++;
        $display("FAIL %s model: code=%0h exp=%0h ready=%0b exp=%0b tap_ok=%0b",
                 cur_req, wiper_code, m_code, ld_ready, !m_act,
                 tap_en == (256'(1) << m_tap_code));
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); ld_valid = 1'b1; ld_data = v;
    @(negedge clk); ld_valid = 1'b0;
    wait_cyc(2);
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk); scl_in = c; sda_in = d;
    wait_cyc(5);
  endtask

  task automatic pulse(input logic d);
    lines(1'b0, d); lines(1'b1, d); lines(1'b0, d);
  endtask

  task automatic begin_step();
    lines(1'b0, 1'b0);
    @(negedge clk); step_start = 1'b1;
    @(negedge clk); step_start = 1'b0;
    wait_cyc(2);
  endtask

  task automatic send_stop();
    lines(1'b0, 1'b0); lines(1'b1, 1'b0); lines(1'b1, 1'b1);
  endtask

  task automatic send_start();
    lines(1'b0, 1'b1); lines(1'b1, 1'b1); lines(1'b1, 1'b0); lines(1'b0, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    cur_req = "R1";
    check("R1 code", wiper_code, 0);
    check("R1 taps", int'(tap_en == 256'(1)), 1);
    check("R1 ready", ld_ready, 1);

    cur_req = "R11";
    pulse(1'b1); pulse(1'b0);
    check("R11 idle bus", wiper_code, 0);

    cur_req = "R2";
    load(8'h40);
    check("R2 host write", wiper_code, 8'h40);
    check("R3 tap 64", tap_en[64], 1);
    check("R3 one hot", $countones(tap_en), 1);
    cur_req = "R4";
    load(8'hFF);
    check("R4 high terminal", tap_en[255], 1);
    load(8'h00);
    check("R4 low terminal", tap_en[0], 1);

    cur_req = "R5";
    load(8'h10);
    check("R2 recall", wiper_code, 8'h10);
    begin_step();
    check("R9 ready low", ld_ready, 0);
    for (int i = 0; i < 3; i++) pulse(1'b1);
    check("R5 three up", wiper_code, 8'h13);
    check("R3 tap 13h", tap_en[8'h13], 1);
    cur_req = "R6";
    for (int i = 0; i < 5; i++) pulse(1'b0);
    check("R6 five down", wiper_code, 8'h0E);
    cur_req = "R8";
    send_stop();
    check("R8 stop no step", wiper_code, 8'h0E);
    check("R8 ready back", ld_ready, 1);
    pulse(1'b1); pulse(1'b0);
    check("R8 after stop", wiper_code, 8'h0E);

    cur_req = "R7";
    load(8'hFE);
    begin_step();
    for (int i = 0; i < 3; i++) pulse(1'b1);
    check("R7 top hold", wiper_code, 8'hFF);
    send_stop();
    load(8'h01);
    begin_step();
    for (int i = 0; i < 3; i++) pulse(1'b0);
    check("R7 bottom hold", wiper_code, 8'h00);

    cur_req = "R9";
    @(negedge clk); ld_valid = 1'b1; ld_data = 8'h55;
    @(negedge clk); ld_valid = 1'b0;
    wait_cyc(2);
    check("R9 load refused", wiper_code, 8'h00);
    check("R9 ready", ld_ready, 0);

    cur_req = "R10";
    send_start();
    check("R10 start no step", wiper_code, 8'h00);
    check("R10 ready back", ld_ready, 1);
    pulse(1'b1);
    check("R10 mode ended", wiper_code, 8'h00);
    load(8'h2A);
    check("R2 transfer", wiper_code, 8'h2A);

    wait_cyc(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule